// File: doc/BRIEF.md
# Dual-Output Gate Pulse Steering

This block takes the pulse train of a resonant converter's one-shot timer and routes it to two gate-drive outputs, A and B. Two static configuration bits pick one of four modes. One bit chooses between alternating outputs, where the two outputs take turns, and parallel outputs, where both outputs carry the same waveform. The other bit chooses how the pulse is read. In on-time mode the pulse is the conduction interval of the switch, as used in zero-current switching. In off-time mode the pulse is the dead interval, as used in zero-voltage switching.

A toggle register advances once per end-of-pulse strobe and picks the output that is served in the alternating modes. In off-time alternating mode the result is a pair of square waves that never overlap, and the one-shot pulse forms the dead time between them. A force-low request covers under-voltage lockout and fault shutdown. It drives both outputs low and clears the toggle, so that output A is the first output served after the request is released. Both outputs are registered, which keeps them free of glitches when the toggle changes.

Top module: `pulse_steer`

## Requirements
- R1: While rstN is low, outA and outB are 0 and the toggle selects output A.
- R2: Mode encoding: modeParallel=1 means parallel and modeOnTime=1 means on-time. In on-time parallel mode, outA and outB both equal pulseIn, delayed by one clock.
- R3: In off-time parallel mode (modeParallel=1, modeOnTime=0), outA and outB both equal the inverse of pulseIn, delayed by one clock, so both are low during a pulse.
- R4: In on-time alternating mode (modeParallel=0, modeOnTime=1), each pulse appears only on the selected output. Toggle value 0 selects A and 1 selects B. The toggle inverts on the clock edge that samples pulseEnd=1, and pulseEnd marks the last cycle of a pulse.
- R5: In off-time alternating mode (modeParallel=0, modeOnTime=0), the selected output is high while pulseIn is low. Both outputs are low while pulseIn is high, and the two outputs are never high together.
- R6: A clock edge that samples forceLow=1 drives both outputs low and clears the toggle, regardless of mode. forceLow takes precedence over a pulseEnd in the same cycle.
- R7: After forceLow is released, the first output served in an alternating mode is A.
- R8: Each output is a register that reflects the inputs sampled at the previous clock edge. There is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pulseIn | input | 1 | One-shot pulse, high while the pulse is active |
| pulseEnd | input | 1 | One-cycle strobe on the last cycle of a pulse |
| modeParallel | input | 1 | 1 = parallel outputs, 0 = alternating outputs |
| modeOnTime | input | 1 | 1 = pulse is on-time, 0 = pulse is off-time |
| forceLow | input | 1 | Lockout or fault request that holds both outputs low |
| outA | output | 1 | Gate drive A |
| outB | output | 1 | Gate drive B |

## Verification
The toggle advance on pulseEnd and the clearing action of forceLow can fall on the same clock edge. The bench runs force-low windows on a fixed period that is coprime with the pulse period, so across the sweep some windows begin exactly on a pulseEnd cycle. The bench model resolves that collision in favour of forceLow. The first pulse after each release must therefore land on A, and every cycle's outputs are compared against this model in all four modes.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int NUM_OUTS = 2;
  localparam int SEL_W = $clog2(NUM_OUTS);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             blank;
  } steer_strobe_t;
endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          pulseEnd,
  input  logic          forceLow,
  output steer_strobe_t strb
);
  logic [SEL_W-1:0] selQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         selQ <= '0;
    else if (forceLow) selQ <= '0;
    else if (pulseEnd) selQ <= (selQ == SEL_W'(NUM_OUTS-1)) ? '0 : selQ + 1'b1;
  end

  always_comb begin
    strb.sel   = selQ;
    strb.blank = forceLow;
  end

  p_toggle_adv_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pulseEnd && !forceLow) |=> (selQ != $past(selQ)));
  p_force_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    forceLow |=> (selQ == '0));
  p_release_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(forceLow) |-> (selQ == '0));
endmodule

// File: rtl/steer_dp.sv
module steer_dp
  import steer_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          pulseIn,
  input  logic          modeParallel,
  input  logic          modeOnTime,
  input  steer_strobe_t strb,
  output logic [NUM_OUTS-1:0] drive
);
  logic active;
  assign active = modeOnTime ? pulseIn : ~pulseIn;

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
    logic picked;
    logic nxt;
    assign picked = modeParallel | (strb.sel == SEL_W'(i));
    assign nxt    = active & picked & ~strb.blank;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) drive[i] <= 1'b0;
      else       drive[i] <= nxt;
    end
  end

  p_blank_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.blank |=> (drive == '0));
  p_alt_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !modeParallel |=> $onehot0(drive));
  p_offtime_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!modeOnTime && pulseIn) |=> (drive == '0));
  p_par_same_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeParallel && !strb.blank) |=> (drive[0] == drive[NUM_OUTS-1]));
endmodule

// File: rtl/pulse_steer.sv
module pulse_steer
  import steer_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic pulseIn,
  input  logic pulseEnd,
  input  logic modeParallel,
  input  logic modeOnTime,
  input  logic forceLow,
  output logic outA,
  output logic outB
);
  steer_strobe_t strb;
  logic [NUM_OUTS-1:0] drive;

  steer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pulseEnd(pulseEnd), .forceLow(forceLow), .strb(strb)
  );

  steer_dp u_dp (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .modeParallel(modeParallel),
    .modeOnTime(modeOnTime), .strb(strb), .drive(drive)
  );

  assign outA = drive[0];
  assign outB = drive[1];

  p_reset_low_r1: assert property (@(posedge clk) !rstN |-> (!outA && !outB));
endmodule

// File: tb/sim_pulse_steer.sv
`timescale 1ns/1ps
module sim_pulse_steer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pulseIn = 1'b0, pulseEnd = 1'b0, modeParallel = 1'b0, modeOnTime = 1'b0, forceLow = 1'b0;
  logic outA, outB;
  int   nRun = 0, nFail = 0;
  logic mSel = 1'b0;
  logic prevForce = 1'b0;

  always #5 clk = ~clk;

  pulse_steer u0 (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .pulseEnd(pulseEnd),
    .modeParallel(modeParallel), .modeOnTime(modeOnTime), .forceLow(forceLow),
    .outA(outA), .outB(outB)
  );

  task automatic check(input string tag, input logic a, input logic b, input logic ea, input logic eb);
    nRun++;
    if (a !== ea || b !== eb) begin
      nFail++;
      $display("FAIL %s: A/B=%b%b expected %b%b", tag, a, b, ea, eb);
    end
  endtask

  // drive at negedge, compare one edge later (R8: one-cycle registered latency)
  task automatic step(input logic p, input logic e, input logic f);
    logic act, ea, eb;
    string tag;
    pulseIn = p; pulseEnd = e; forceLow = f;
    act = modeOnTime ? p : ~p;
    if (f) begin ea = 0; eb = 0; end
    else if (modeParallel) begin ea = act; eb = act; end
    else begin ea = act & ~mSel; eb = act & mSel; end
    if (f) tag = "R6";
    else if (prevForce && !modeParallel) tag = "R7";
    else if (modeParallel) tag = modeOnTime ? "R2" : "R3";
    else tag = modeOnTime ? "R4" : "R5";
    if (f) mSel = 1'b0; else if (e) mSel = ~mSel;
    prevForce = f;
    @(posedge clk); #1;
    check(tag, outA, outB, ea, eb);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: expired, expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outA, outB, 1'b0, 1'b0);
    pulseIn = 1'b1;
    modeParallel = 1'b1; modeOnTime = 1'b1;
    @(posedge clk); #1;
    check("R1", outA, outB, 1'b0, 1'b0);
    @(negedge clk);
    pulseIn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      modeParallel = m[0]; modeOnTime = m[1];
      step(0, 0, 1);
      for (int len = 1; len <= 4; len++) begin
        for (int gap = 1; gap <= 3; gap++) begin
          for (int rep = 0; rep < 6; rep++) begin
            for (int c = 0; c < len + gap; c++) begin
              logic p, e, f;
              int t;
              t = (rep * (len + gap) + c + len * 5 + gap);
              p = (c < len);
              e = (c == len - 1);
              f = ((t % 13) == 0) || ((t % 13) == 1 && gap == 2);
              step(p, e, f);
            end
          end
        end
      end
      // R6 collision: forceLow exactly on a pulseEnd, then R7 first pulse to A
      step(1, 0, 0); step(1, 1, 1); step(0, 0, 0);
      step(1, 1, 0); step(0, 0, 0); step(1, 1, 0); step(0, 0, 0);
    end
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule